// File: doc/BRIEF.md
# Multi-Mode Interrupt Source Selector

This block turns three interrupt events into host notifications. The events are error (source 1), ready (source 2) and reset (source 3). Every event marks a sticky per-source flag. An event whose enable bit is set is delivered in one of two ways. When message-signalled interrupts are turned on, the block emits a one-cycle vector-notify pulse that carries a vector number. When they are off, it raises a level-sensitive legacy line. Software clears the flags by writing to them. The legacy line falls only when such a write leaves every flag at zero while message mode is off.

Message delivery runs through a two-state arbiter, `ARB_IDLE` and `ARB_FIRE`. The transition `ARB_IDLE -> ARB_FIRE` is taken when a pending source exists. The lowest-numbered pending source wins, so error goes first, then ready, then reset. The arbiter latches that source's vector number at this point. The transition `ARB_FIRE -> ARB_IDLE` is always taken and retires the served source. The legacy line is a second two-state machine, `LEG_LOW` and `LEG_HIGH`. The transition `LEG_LOW -> LEG_HIGH` is taken on an enabled event while message mode is off. The transition `LEG_HIGH -> LEG_LOW` is taken on a flag write, with message mode off, that leaves all flags zero. The host requests 4 vectors. The vector number equals the source number only when all 4 were granted; otherwise every source uses vector 0.

Top module: `isel_top`

## Requirements
- R1: After reset, the enable byte and all three flag bytes read zero, `msi_fire_o` is low and `legacy_irq_o` is low.
- R2: An event on source n (`evt_i` bit n-1) sets that source's flag byte to 1 in the next cycle, whether or not the source is enabled. A disabled source produces neither a notify pulse nor a legacy assertion.
- R3: With message mode on and `vec_alloc_i` equal to 4 at selection time, a source's notify pulse carries vector n for source n (error 1, ready 2, reset 3). A lone enabled event is notified in the second cycle after it is sampled.
- R4: With message mode on and `vec_alloc_i` below 4 at selection time, every notify pulse carries vector 0.
- R5: `msi_fire_o` is high for exactly one cycle per notification, and two notifications are separated by at least one low cycle.
- R6: Events that are pending together are notified in priority order: error, then ready, then reset.
- R7: With message mode off, an enabled event raises `legacy_irq_o` in the next cycle and produces no notify pulse.
- R8: A write to source n's flag (`flag_wr_i` bit n-1) stores `flag_wdata_i` in that flag byte. An event for the same source in the same cycle takes precedence and stores 1.
- R9: `legacy_irq_o` falls only in the cycle after a flag write made while message mode is off that leaves all three flag bytes zero. It stays high while any flag is non-zero.
- R10: A write strobe on `en_wr_i` stores `en_wdata_i` as the enable byte. Bit n-1 enables source n, and bits 3 to 7 gate nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 3 | Event pulses; bit 0 error, bit 1 ready, bit 2 reset |
| en_wr_i | input | 1 | Enable-byte write strobe |
| en_wdata_i | input | 8 | Enable-byte write data |
| flag_wr_i | input | 3 | Per-source flag write strobes |
| flag_wdata_i | input | 8 | Data stored into every strobed flag |
| msi_on_i | input | 1 | Message-signalled mode on |
| vec_alloc_i | input | 3 | Number of vectors the host granted |
| msi_fire_o | output | 1 | Vector-notify pulse |
| msi_vec_o | output | 2 | Vector number, valid with the pulse |
| legacy_irq_o | output | 1 | Legacy level interrupt |
| enable_o | output | 8 | Current enable byte |
| flags_o | output | 24 | Flag bytes; [7:0] error, [15:8] ready, [23:16] reset |

## Verification
The bench builds the block with its default parameters: three sources, 8-bit flag and enable bytes, and 4 requested vectors. With these values the grant count sweeps through every value from 0 to 4, so both the collapsed and the full vector mappings occur. Triple-simultaneous events exercise the whole priority chain. Random flag writes with mostly zero data reach the legacy release both with some flags still set and with all of them cleared.

// File: rtl/isel_pkg.sv
package isel_pkg;

    typedef enum logic [0:0] {
        ARB_IDLE = 1'b0,
        ARB_FIRE = 1'b1
    } arb_state_e;

    typedef enum logic [0:0] {
        LEG_LOW  = 1'b0,
        LEG_HIGH = 1'b1
    } leg_state_e;

endpackage

// File: rtl/isel_flag_bank.sv
module isel_flag_bank #(
    parameter int N_SRC  = 3,
    parameter int FLAG_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        evt_i,
    input  logic [N_SRC-1:0]        wr_i,
    input  logic [FLAG_W-1:0]       wdata_i,
    output logic [N_SRC*FLAG_W-1:0] flags_o,
    output logic                    any_next_o
);

    logic [N_SRC*FLAG_W-1:0] flags_q;
    logic [N_SRC*FLAG_W-1:0] flags_d;

    // Per-source next value: an event beats a software write.
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        always_comb begin
            flags_d[s*FLAG_W +: FLAG_W] = flags_q[s*FLAG_W +: FLAG_W];
            if (wr_i[s]) begin
                flags_d[s*FLAG_W +: FLAG_W] = wdata_i;
            end
            if (evt_i[s]) begin
                flags_d[s*FLAG_W +: FLAG_W] = FLAG_W'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[s*FLAG_W +: FLAG_W] <= '0;
            end else begin
                flags_q[s*FLAG_W +: FLAG_W] <= flags_d[s*FLAG_W +: FLAG_W];
            end
        end
    end

    assign any_next_o = |flags_d;
    assign flags_o    = flags_q;

endmodule

// File: rtl/isel_arb.sv
module isel_arb
    import isel_pkg::*;
#(
    parameter int N_SRC   = 3,
    parameter int VEC_REQ = 4,
    parameter int VEC_W   = 2,
    parameter int ALLOC_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   req_i,
    input  logic [ALLOC_W-1:0] alloc_i,
    output logic               fire_o,
    output logic [VEC_W-1:0]   vec_o
);

    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    arb_state_e        state_q, state_d;
    logic [N_SRC-1:0]  pend_q, pend_d;
    logic [SEL_W-1:0]  sel_q, sel_d, pick;
    logic [VEC_W-1:0]  vec_q, vec_d;
    logic              full_grant;

    // Lowest index wins: scan from the top so the last hit is the lowest.
    always_comb begin
        pick = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                pick = SEL_W'(i);
            end
        end
    end

    assign full_grant = (alloc_i == ALLOC_W'(VEC_REQ));

    // Next-state process
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        vec_d   = vec_q;
        pend_d  = pend_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (|pend_q) begin
                    state_d = ARB_FIRE;
                    sel_d   = pick;
                    vec_d   = full_grant ? VEC_W'(pick) + VEC_W'(1) : '0;
                end
            end
            ARB_FIRE: begin
                state_d       = ARB_IDLE;
                pend_d[sel_q] = 1'b0;
            end
            default: state_d = ARB_IDLE;
        endcase
        pend_d = pend_d | req_i;
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            pend_q  <= '0;
            sel_q   <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            sel_q   <= sel_d;
            vec_q   <= vec_d;
        end
    end

    // Output process
    always_comb begin
        fire_o = 1'b0;
        unique case (state_q)
            ARB_IDLE: fire_o = 1'b0;
            ARB_FIRE: fire_o = 1'b1;
            default:  fire_o = 1'b0;
        endcase
        vec_o = vec_q;
    end

endmodule

// File: rtl/isel_legacy.sv
module isel_legacy
    import isel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);

    leg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LEG_LOW:  if (set_i) state_d = LEG_HIGH;
            LEG_HIGH: if (clr_i && !set_i) state_d = LEG_LOW;
            default:  state_d = LEG_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LEG_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            LEG_LOW:  irq_o = 1'b0;
            LEG_HIGH: irq_o = 1'b1;
            default:  irq_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/isel_top.sv
module isel_top #(
    parameter int N_SRC  = 3,
    parameter int FLAG_W = 8,
    parameter int EN_W   = 8,
    parameter int VEC_REQ_P = N_SRC + 1,
    parameter int VEC_W_P   = $clog2(VEC_REQ_P),
    parameter int ALLOC_W_P = $clog2(VEC_REQ_P + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        evt_i,
    input  logic                    en_wr_i,
    input  logic [EN_W-1:0]         en_wdata_i,
    input  logic [N_SRC-1:0]        flag_wr_i,
    input  logic [FLAG_W-1:0]       flag_wdata_i,
    input  logic                    msi_on_i,
    input  logic [ALLOC_W_P-1:0]    vec_alloc_i,
    output logic                    msi_fire_o,
    output logic [VEC_W_P-1:0]      msi_vec_o,
    output logic                    legacy_irq_o,
    output logic [EN_W-1:0]         enable_o,
    output logic [N_SRC*FLAG_W-1:0] flags_o
);

    logic [EN_W-1:0]  en_q;
    logic [N_SRC-1:0] live_evt;
    logic             any_next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr_i) begin
            en_q <= en_wdata_i;
        end
    end

    assign live_evt = evt_i & en_q[N_SRC-1:0];
    assign enable_o = en_q;

    isel_flag_bank #(
        .N_SRC  (N_SRC),
        .FLAG_W (FLAG_W)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .wr_i       (flag_wr_i),
        .wdata_i    (flag_wdata_i),
        .flags_o    (flags_o),
        .any_next_o (any_next)
    );

    isel_arb #(
        .N_SRC   (N_SRC),
        .VEC_REQ (VEC_REQ_P),
        .VEC_W   (VEC_W_P),
        .ALLOC_W (ALLOC_W_P)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (live_evt & {N_SRC{msi_on_i}}),
        .alloc_i (vec_alloc_i),
        .fire_o  (msi_fire_o),
        .vec_o   (msi_vec_o)
    );

    isel_legacy u_leg (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i ((|live_evt) && !msi_on_i),
        .clr_i ((|flag_wr_i) && !msi_on_i && !any_next),
        .irq_o (legacy_irq_o)
    );

endmodule

// File: rtl/isel_chk.sv
module isel_chk #(
    parameter int N_SRC   = 3,
    parameter int FLAG_W  = 8,
    parameter int VEC_REQ = 4,
    parameter int VEC_W   = 2,
    parameter int ALLOC_W = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_SRC-1:0]        evt_i,
    input logic [N_SRC-1:0]        flag_wr_i,
    input logic [ALLOC_W-1:0]      vec_alloc_i,
    input logic                    msi_fire_o,
    input logic [VEC_W-1:0]        msi_vec_o,
    input logic                    legacy_irq_o,
    input logic [N_SRC*FLAG_W-1:0] flags_o
);

    AST_FIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        msi_fire_o |=> !msi_fire_o); // R5

    AST_VEC_COLLAPSE: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_fire_o && ($past(vec_alloc_i) != ALLOC_W'(VEC_REQ))) |-> (msi_vec_o == '0)); // R4

    AST_VEC_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_fire_o && ($past(vec_alloc_i) == ALLOC_W'(VEC_REQ))) |-> (msi_vec_o != '0)); // R3

    AST_LEGACY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_irq_o && (flag_wr_i == '0)) |=> legacy_irq_o); // R9

    AST_FLAG_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[0] |=> (flags_o[FLAG_W-1:0] == FLAG_W'(1))); // R2

endmodule

bind isel_top isel_chk #(
    .N_SRC   (N_SRC),
    .FLAG_W  (FLAG_W),
    .VEC_REQ (VEC_REQ_P),
    .VEC_W   (VEC_W_P),
    .ALLOC_W (ALLOC_W_P)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt_i),
    .flag_wr_i    (flag_wr_i),
    .vec_alloc_i  (vec_alloc_i),
    .msi_fire_o   (msi_fire_o),
    .msi_vec_o    (msi_vec_o),
    .legacy_irq_o (legacy_irq_o),
    .flags_o      (flags_o)
);

// File: tb/isel_top_tb.sv
module isel_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  evt_i = '0;
    logic        en_wr_i = 1'b0;
    logic [7:0]  en_wdata_i = '0;
    logic [2:0]  flag_wr_i = '0;
    logic [7:0]  flag_wdata_i = '0;
    logic        msi_on_i = 1'b0;
    logic [2:0]  vec_alloc_i = '0;
    logic        msi_fire_o;
    logic [1:0]  msi_vec_o;
    logic        legacy_irq_o;
    logic [7:0]  enable_o;
    logic [23:0] flags_o;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference state, built from the requirements
    logic [7:0] m_en = '0;
    logic [7:0] m_flag [3] = '{8'h0, 8'h0, 8'h0};
    logic       m_leg = 1'b0;
    logic [2:0] m_pend = '0;
    logic       m_fire = 1'b0;
    int         m_sel = 0;
    logic [1:0] m_vec = '0;

    always #2 clk = ~clk;

    isel_top u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .en_wr_i(en_wr_i),
        .en_wdata_i(en_wdata_i), .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i),
        .msi_on_i(msi_on_i), .vec_alloc_i(vec_alloc_i), .msi_fire_o(msi_fire_o),
        .msi_vec_o(msi_vec_o), .legacy_irq_o(legacy_irq_o), .enable_o(enable_o),
        .flags_o(flags_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_vec(input int src, input logic [2:0] alloc);
        return (alloc == 3'd4) ? 2'(src + 1) : 2'd0;
    endfunction

    task automatic model_update();
        logic [7:0] nf [3];
        logic [2:0] live;
        logic [2:0] np;
        live = evt_i & m_en[2:0];
        for (int i = 0; i < 3; i++) begin
            nf[i] = m_flag[i];
            if (flag_wr_i[i]) nf[i] = flag_wdata_i;
            if (evt_i[i]) nf[i] = 8'd1;
        end
        np = m_pend;
        if (m_fire) begin
            np[m_sel] = 1'b0;
            m_fire = 1'b0;
        end else if (|m_pend) begin
            m_fire = 1'b1;
            m_sel = m_pend[0] ? 0 : (m_pend[1] ? 1 : 2);   // R6 priority
            m_vec = exp_vec(m_sel, vec_alloc_i);
        end
        if (msi_on_i) np = np | live;
        m_pend = np;
        if ((|live) && !msi_on_i) m_leg = 1'b1;
        else if ((|flag_wr_i) && !msi_on_i && ((nf[0] | nf[1] | nf[2]) == 8'd0)) m_leg = 1'b0;
        for (int i = 0; i < 3; i++) m_flag[i] = nf[i];
        if (en_wr_i) m_en = en_wdata_i;
    endtask

    task automatic compare();
        chk(msi_fire_o == m_fire, "R5 notify pulse", int'(msi_fire_o), int'(m_fire));
        if (m_fire)
            chk(msi_vec_o == m_vec, (m_vec == 0) ? "R4 vector" : "R3 vector",
                int'(msi_vec_o), int'(m_vec));
        chk(legacy_irq_o == m_leg, "R9 legacy level", int'(legacy_irq_o), int'(m_leg));
        for (int i = 0; i < 3; i++)
            chk(flags_o[i*8 +: 8] == m_flag[i], "R8 flag byte", int'(flags_o[i*8 +: 8]), int'(m_flag[i]));
        chk(enable_o == m_en, "R10 enable byte", int'(enable_o), int'(m_en));
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        model_update();
        compare();
    endtask

    task automatic idle_in();
        evt_i = '0; en_wr_i = 1'b0; flag_wr_i = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seq [3];
        int got;
        void'($urandom(32'h1A5E_0C3D));
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        chk(enable_o == 8'h0 && flags_o == 24'h0, "R1 reset bytes", int'(flags_o), 0);
        chk(!msi_fire_o && !legacy_irq_o, "R1 reset outputs", int'(legacy_irq_o), 0);

        // R2: disabled source marks its flag and sends nothing
        msi_on_i = 1'b1; vec_alloc_i = 3'd4; evt_i = 3'b001;
        step(); idle_in();
        chk(flags_o[7:0] == 8'd1, "R2 flag set", int'(flags_o[7:0]), 1);
        step();
        chk(!msi_fire_o && !legacy_irq_o, "R2 disabled silent", int'(msi_fire_o), 0);

        // R10: only low bits gate the sources
        en_wr_i = 1'b1; en_wdata_i = 8'hF8; step(); idle_in();
        chk(enable_o == 8'hF8, "R10 store", int'(enable_o), 8'hF8);
        evt_i = 3'b111; step(); idle_in(); step();
        chk(!msi_fire_o, "R10 upper bits inert", int'(msi_fire_o), 0);
        en_wr_i = 1'b1; en_wdata_i = 8'h07; step(); idle_in();

        // R3: full grant, ready source -> vector 2 on second edge
        evt_i = 3'b010; step(); idle_in(); step();
        chk(msi_fire_o && msi_vec_o == 2'd2, "R3 ready vector", int'(msi_vec_o), 2);
        step();

        // R6: all three together -> 1,2,3
        evt_i = 3'b111; step(); idle_in();
        got = 0;
        for (int k = 0; k < 8; k++) begin
            step();
            if (msi_fire_o && got < 3) begin seq[got] = int'(msi_vec_o); got++; end
        end
        chk(got == 3 && seq[0] == 1 && seq[1] == 2 && seq[2] == 3, "R6 order", seq[0]*100 + seq[1]*10 + seq[2], 123);

        // R4: partial grant collapses to 0
        vec_alloc_i = 3'd2; evt_i = 3'b100; step(); idle_in(); step();
        chk(msi_fire_o && msi_vec_o == 2'd0, "R4 collapsed vector", int'(msi_vec_o), 0);
        step();

        // R7: legacy mode
        msi_on_i = 1'b0; flag_wr_i = 3'b111; flag_wdata_i = 8'h00; step(); idle_in();
        evt_i = 3'b001; step(); idle_in();
        chk(legacy_irq_o, "R7 legacy raised", int'(legacy_irq_o), 1);
        step(); step();
        chk(!msi_fire_o, "R7 no notify", int'(msi_fire_o), 0);

        // R9: release only when all flags clear
        evt_i = 3'b010; step(); idle_in();
        flag_wr_i = 3'b001; step(); idle_in();
        chk(legacy_irq_o, "R9 hold with flag set", int'(legacy_irq_o), 1);
        flag_wr_i = 3'b010; step(); idle_in();
        chk(!legacy_irq_o, "R9 release", int'(legacy_irq_o), 0);

        // R8: write stores; same-cycle event wins
        flag_wr_i = 3'b100; flag_wdata_i = 8'h5A; step(); idle_in();
        chk(flags_o[23:16] == 8'h5A, "R8 write stores", int'(flags_o[23:16]), 8'h5A);
        flag_wr_i = 3'b100; flag_wdata_i = 8'h00; evt_i = 3'b100; step(); idle_in();
        chk(flags_o[23:16] == 8'h01, "R8 event wins", int'(flags_o[23:16]), 1);

        // Random phase against the reference model
        for (int c = 0; c < 4000; c++) begin
            evt_i        = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
            flag_wr_i    = (($urandom % 5) == 0) ? 3'($urandom) : 3'b000;
            flag_wdata_i = (($urandom % 3) == 0) ? 8'($urandom) : 8'h00;
            en_wr_i      = (($urandom % 30) == 0);
            en_wdata_i   = 8'($urandom);
            if (($urandom % 40) == 0) msi_on_i = ~msi_on_i;
            if (($urandom % 10) == 0) vec_alloc_i = 3'($urandom % 5);
            step();
        end
        idle_in();
        finish_run();
    end

endmodule